// File: doc/BRIEF.md
# Dual-Word Shift-and-Truncate Unit

This unit takes a 64-bit operand that holds two signed 32-bit words and a 32-bit shift control. It moves both words by one signed shift amount, then packs the low halfword of each shifted word into a 32-bit result. The shift amount comes from a 7-bit two's-complement field at the bottom of the control word. A positive amount selects an arithmetic right shift. A zero or negative amount selects a left shift by its magnitude. The most negative amount always yields zero.

Before it is shifted, each word is sign-extended to 64 bits. A right shift of up to 63 places therefore fills the word with copies of its sign bit. A left shift never brings in bits from the other word. The input is a valid/ready pair that accepts a request on every cycle. The result is registered and appears one cycle after a request is accepted. It then stays unchanged until the next request.

Top module: `dw_shift_trunc`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and `out_result` is 0 until the first request is accepted.
- R2: `in_ready` is always 1. A cycle with `in_valid` high makes `out_valid` high on the next cycle. A cycle with `in_valid` low makes it low on the next cycle.
- R3: When `in_valid` is low, `out_result` keeps its previous value, whatever the operand and control inputs carry.
- R4: The shift amount is `in_ctrl[6:0]` read as two's complement (-64..63). Control bits 31:7 have no effect on the result.
- R5: An amount of 1..63 shifts each word right arithmetically, after sign extension to 64 bits.
- R6: An amount of 0..-63 shifts each word left by the magnitude, with zeros entering from the bottom.
- R7: An amount of -64 (`in_ctrl[6:0]` = 7'h40) gives a result of 0 for any operand.
- R8: The low 16 bits of shifted word 0 (`in_operand[31:0]`) form result bits 15:0. The low 16 bits of shifted word 1 (`in_operand[63:32]`) form result bits 31:16.
- R9: A right shift of 63 gives a halfword in which every bit equals the sign bit of its source word. For example, operand 0xFFFFFFFF22222222 with amount 0 gives 0xFFFF2222, and operand 0x1111111122222222 with amount 5 gives 0x88881111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can accept a request (always 1) |
| in_operand | input | 64 | Two signed 32-bit words |
| in_ctrl | input | 32 | Shift control; bits 6:0 hold the amount |
| out_valid | output | 1 | Result register holds a new result |
| out_result | output | 32 | Packed pair of shifted halfwords |

## Verification
The hardest cases to reach are the two ends of the 7-bit field. These are the amount -64, which must give zero, and large right shifts, where the sign fill from the upper half of each extended word reaches the kept halfword. Uniform random controls hit these ends rarely. The stimulus therefore applies them on purpose: a directed sweep covers all 128 field values with fixed operands that have negative and positive words. It also repeats the corner amounts with random upper control bits. After that comes a long random run that mixes idle cycles into the traffic.

// File: rtl/dw_shift_trunc.sv
module dw_shift_trunc #(
  parameter int LANE_W  = 32,
  parameter int PACK_W  = 16,
  parameter int SHAMT_W = 7,
  parameter int CTRL_W  = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [2*LANE_W-1:0]   in_operand,
  input  logic [CTRL_W-1:0]     in_ctrl,
  output logic                  out_valid,
  output logic [2*PACK_W-1:0]   out_result
);
  localparam int EXT_W = 2 * LANE_W;
  localparam int RES_W = 2 * PACK_W;

  logic [SHAMT_W-1:0] amt;
  logic [SHAMT_W-1:0] mag;
  logic               go_right;
  logic               kill;
  logic [RES_W-1:0]   packed_res;
  logic               unused_ctrl;

  assign amt         = in_ctrl[SHAMT_W-1:0];
  assign unused_ctrl = ^in_ctrl[CTRL_W-1:SHAMT_W];
  assign go_right    = !amt[SHAMT_W-1] && (amt != '0);
  assign mag         = go_right ? amt : (~amt + 1'b1);
  assign kill        = !go_right && mag[SHAMT_W-1];
  assign in_ready    = 1'b1;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic signed [EXT_W-1:0] ext;
    logic signed [EXT_W-1:0] shifted;
    logic                    unused_hi;

    assign ext       = $signed({{LANE_W{in_operand[g*LANE_W+LANE_W-1]}},
                                in_operand[g*LANE_W +: LANE_W]});
    assign shifted   = go_right ? (ext >>> mag) : (ext << mag);
    assign unused_hi = ^shifted[EXT_W-1:PACK_W];
    assign packed_res[g*PACK_W +: PACK_W] = kill ? '0 : shifted[PACK_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= in_valid && in_ready;
      if (in_valid && in_ready) out_result <= packed_res;
    end
  end
endmodule

// File: rtl/dw_shift_trunc_chk.sv
module dw_shift_trunc_chk #(
  parameter int LANE_W  = 32,
  parameter int PACK_W  = 16,
  parameter int SHAMT_W = 7,
  parameter int CTRL_W  = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [2*LANE_W-1:0] in_operand,
  input logic [CTRL_W-1:0]   in_ctrl,
  input logic                out_valid,
  input logic [2*PACK_W-1:0] out_result
);
  localparam logic [SHAMT_W-1:0] MOST_NEG = {1'b1, {(SHAMT_W-1){1'b0}}};
  localparam logic [SHAMT_W-1:0] MOST_POS = {1'b0, {(SHAMT_W-1){1'b1}}};

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R2
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_result)); // R3
  AST_MOST_NEG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ctrl[SHAMT_W-1:0] == MOST_NEG) |=> out_result == '0); // R7
  AST_ZERO_SHIFT_PACK: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ctrl[SHAMT_W-1:0] == '0) |=>
      out_result == {$past(in_operand[LANE_W +: PACK_W]), $past(in_operand[PACK_W-1:0])}); // R8
  AST_SIGN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ctrl[SHAMT_W-1:0] == MOST_POS) |=>
      out_result == {{PACK_W{$past(in_operand[2*LANE_W-1])}}, {PACK_W{$past(in_operand[LANE_W-1])}}}); // R9
endmodule

bind dw_shift_trunc dw_shift_trunc_chk #(
  .LANE_W(LANE_W), .PACK_W(PACK_W), .SHAMT_W(SHAMT_W), .CTRL_W(CTRL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_operand(in_operand),
  .in_ctrl(in_ctrl), .out_valid(out_valid), .out_result(out_result)
);

// File: tb/dw_shift_trunc_test.sv
module dw_shift_trunc_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_operand = '0;
  logic [31:0] in_ctrl = '0;
  logic        out_valid;
  logic [31:0] out_result;

  int compared = 0;
  int mismatched = 0;
  bit exp_valid = 1'b0;
  logic [31:0] exp_res = '0;
  string prev_tag = "R1";

  always #2 clk = ~clk;

  dw_shift_trunc uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_operand(in_operand), .in_ctrl(in_ctrl),
    .out_valid(out_valid), .out_result(out_result)
  );

  function automatic logic [31:0] model(logic [63:0] op, logic [31:0] c);
    int amt;
    logic [15:0] h [2];
    amt = c[6] ? int'(c[6:0]) - 128 : int'(c[6:0]);
    for (int i = 0; i < 2; i++) begin
      longint w;
      longint r;
      w = longint'($signed(op[i*32 +: 32]));
      if (amt > 0) r = w >>> amt;
      else if (amt == -64) r = 0;
      else r = w << (-amt);
      h[i] = r[15:0];
    end
    return {h[1], h[0]};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic step(bit v, logic [63:0] op, logic [31:0] c, string tag);
    @(negedge clk);
    check({prev_tag, " valid"}, {31'b0, out_valid}, {31'b0, exp_valid});
    check({prev_tag, " result"}, out_result, exp_res);
    check("R2 ready", {31'b0, in_ready}, 32'd1);
    in_valid = v;
    in_operand = op;
    in_ctrl = c;
    exp_valid = v;
    if (v) exp_res = model(op, c);
    prev_tag = tag;
  endtask

  initial begin
    #800000;
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid in reset", {31'b0, out_valid}, 32'd0);
    check("R1 result in reset", out_result, 32'd0);
    rst_n = 1'b1;
    step(0, 64'hDEAD_BEEF_0123_4567, 32'h7, "R1");
    step(0, 64'h0, 32'h0, "R1");
    step(1, 64'h1111111122222222, 32'd5, "R5 R9 shift 5");
    step(1, 64'h1111111122222222, 32'd63, "R9 shift 63");
    step(1, 64'h1111111122222222, 32'd64, "R7 ctrl 64");
    step(1, 64'h1111111122222222, 32'd127, "R6 ctrl 127");
    step(1, 64'h1111111122222222, 32'd128, "R4 R8 ctrl 128");
    step(1, 64'hFFFFFFFF22222222, 32'd128, "R8 R9 negative word");
    step(0, 64'hAAAA_5555_1234_8765, 32'h45, "R3 idle");
    step(0, 64'h5555_AAAA_8765_1234, 32'h3, "R3 idle");
    step(1, 64'h8000_0000_7FFF_FFFF, 32'h3F, "R9 sign fill");
    step(1, 64'hFFFF_FFFF_FFFF_FFFF, 32'h40, "R7 all ones");
    step(1, 64'h89AB_CDEF_0123_4567, 32'hFFFF_FF80, "R4 upper bits ignored");
    step(1, 64'h89AB_CDEF_0123_4567, 32'h1234_5601, "R4 R5 upper bits");
    for (int a = 0; a < 128; a++) begin
      step(1, 64'hF00D_8001_0BAD_7FFE, 32'(a), "R5 R6 sweep");
      step(1, 64'h8000_0001_7FFF_0003, {$urandom()} << 7 | 32'(a), "R4 sweep upper");
    end
    for (int n = 0; n < 3000; n++) begin
      bit v;
      logic [31:0] c;
      v = ($urandom_range(0, 3) != 0);
      c = $urandom();
      if ($urandom_range(0, 7) == 0) c[6:0] = 7'h40;
      else if ($urandom_range(0, 7) == 0) c[6:0] = 7'h3F;
      step(v, {$urandom(), $urandom()}, c, v ? "R5 R6 R8 random" : "R3 random idle");
    end
    step(0, 64'h0, 32'h0, "R2 drain");
    step(0, 64'h0, 32'h0, "R3 drain");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule